// File: doc/BRIEF.md
# Nibble-Serial Clock Register Access Master

This block is the host-side master for a three-wire serial link to a real-time-clock chip. The link has a chip enable, a serial clock and one data line that the master drives or releases. One transaction reads or writes a single 4-bit register at a 4-bit address. The host gives a one-cycle start together with a direction flag, an address and a write nibble. The block sends the frame one bit at a time and, for a read, returns the nibble it captured, with a one-cycle completion pulse.

Every frame has 16 serial bits. It opens with a command nibble and then the address. A write then sends a second command nibble and the data. A read releases the line after the address, clocks in four bits that it throws away, and then captures four data bits. The serial clock comes from a divider: each half of the serial clock period lasts `HALF_CYC` system clocks. The data line is modelled as an output value, an output enable and an input value, so that the pad can be placed at the chip level.

Top module: `rtcn_master`

## Requirements
- R1: After synchronous reset, `sclk`, `sd_oe`, `ce`, `busy` and `done` are all low and `rdata` is 0.
- R2: The first four serial bits of every frame form a command nibble. In time order these are 1, then the direction bit (1 = read, 0 = write), then 1, then 0.
- R3: Serial bits 4 to 7 carry the address, most significant bit first.
- R4: In a write, serial bits 8 to 11 are the fixed nibble 1, 0, 0, 1, and serial bits 12 to 15 carry the write data, most significant bit first. `sd_oe` stays high for all 16 bits.
- R5: In a read, `sd_oe` is high for serial bits 0 to 7 and low for bits 8 to 15. The values the slave places on the line during bits 8 to 11 have no effect on `rdata`.
- R6: In a read, the values sampled during serial bits 12 to 15 form `rdata`, with bit 12 as the most significant bit. `rdata` updates in the same cycle that `done` rises. A write leaves `rdata` unchanged.
- R7: Each serial bit starts with `sclk` low for `HALF_CYC` system clocks, followed by `sclk` high for `HALF_CYC` system clocks. `sd_out` changes only while `sclk` is low. An input bit is sampled at the system clock edge that raises `sclk`.
- R8: `done` is high for exactly one cycle, 32×`HALF_CYC` cycles after the start was accepted. `busy` is low in that same cycle.
- R9: A start raised while `busy` is high is ignored: the frame in progress runs on unchanged.
- R10: `ce` and `busy` are high from the cycle after an accepted start until the frame's 16 bits are complete. A start presented in the cycle `done` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request one transaction (single-cycle pulse) |
| rd_nwr | input | 1 | 1 = read, 0 = write; sampled with start |
| addr | input | 4 | Register address; sampled with start |
| wdata | input | 4 | Write nibble; sampled with start |
| rdata | output | 4 | Nibble returned by the latest read |
| done | output | 1 | One-cycle pulse at frame completion |
| busy | output | 1 | Transaction in progress |
| ce | output | 1 | Chip enable to the clock chip |
| sclk | output | 1 | Serial clock |
| sd_out | output | 1 | Value driven onto the data line |
| sd_oe | output | 1 | Output enable for the data line |
| sd_in | input | 1 | Value read back from the data line |

## Verification
The embedded properties assume three things about the inputs. `start` is a single-cycle pulse. `rd_nwr`, `addr` and `wdata` matter only in the cycle where `start` is accepted. The slave holds `sd_in` steady around each rising edge of `sclk`. The bench changes all of its inputs only on falling edges of the system clock. Its slave model updates `sd_in` right after it sees each serial clock rise, so the value is stable for at least one system clock before the next rise. Some starts are deliberately placed inside a running frame, and one is placed in the completion cycle. This exercises both the ignore rule and the back-to-back acceptance case.

// File: rtl/rtcn_pkg.sv
package rtcn_pkg;

    localparam int FRAME_BITS = 16;
    localparam int IDX_W      = 5;
    localparam int NIB_W      = 4;
    localparam int OUT_BITS_RD = 8;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_t;

    typedef struct packed {
        logic             rd;
        logic [NIB_W-1:0] addr;
        logic [NIB_W-1:0] wdat;
    } req_t;

    // Serial frame, MSB leaves the wire first.
    function automatic logic [FRAME_BITS-1:0] build_frame(input req_t r);
        logic [NIB_W-1:0] cmd_a;
        logic [NIB_W-1:0] cmd_b;
        cmd_a = {1'b1, r.rd, 1'b1, 1'b0};
        cmd_b = r.rd ? 4'b0000 : 4'b1001;
        return {cmd_a, r.addr, cmd_b, r.rd ? 4'b0000 : r.wdat};
    endfunction

    function automatic logic drives_bit(input logic rd, input logic [IDX_W-1:0] idx);
        return !rd || (idx < IDX_W'(OUT_BITS_RD));
    endfunction

endpackage

// File: rtl/rtcn_clkgen.sv
module rtcn_clkgen #(
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sclk,
    output logic rise,
    output logic fall
);
    localparam int TW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [TW-1:0] TLAST = TW'(HALF_CYC - 1);

    logic [TW-1:0] tmr;
    logic          half_end;

    assign half_end = run && (tmr == TLAST);
    assign rise     = half_end && !sclk;
    assign fall     = half_end &&  sclk;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            tmr  <= '0;
            sclk <= 1'b0;
        end else if (half_end) begin
            tmr  <= '0;
            sclk <= !sclk;
        end else begin
            tmr  <= tmr + 1'b1;
        end
    end

    // Serial clock rests low outside a frame.
    assert_sclk_rest_R7: assert property (@(posedge clk) disable iff (rst)
        !run |=> !sclk);

endmodule

// File: rtl/rtcn_seq.sv
module rtcn_seq
    import rtcn_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             fall,
    output logic             run,
    output logic             load,
    output logic             last_fall,
    output logic [IDX_W-1:0] bit_idx,
    output logic             done
);
    seq_state_t state;

    assign run       = (state == ST_RUN);
    assign load      = start && (state == ST_IDLE);
    assign last_fall = fall && (bit_idx == IDX_W'(FRAME_BITS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_idx <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state   <= ST_RUN;
                        bit_idx <= '0;
                    end
                end
                ST_RUN: begin
                    if (last_fall) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else if (fall) begin
                        bit_idx <= bit_idx + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !run);

    // Mid-frame starts never end the frame early.
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (run && start && !last_fall) |=> run);

endmodule

// File: rtl/rtcn_shift.sv
module rtcn_shift
    import rtcn_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  req_t             req,
    input  logic             rise,
    input  logic             fall,
    input  logic             last_fall,
    input  logic             run,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             sd_in,
    output logic             sd_out,
    output logic             sd_oe,
    output logic [NIB_W-1:0] rdata
);
    logic [FRAME_BITS-1:0] tx_q;
    logic [NIB_W-1:0]      rx_q;
    logic                  rd_q;

    assign sd_out = tx_q[FRAME_BITS-1];
    assign sd_oe  = run && drives_bit(rd_q, bit_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q  <= '0;
            rx_q  <= '0;
            rd_q  <= 1'b0;
            rdata <= '0;
        end else begin
            if (load) begin
                tx_q <= build_frame(req);
                rd_q <= req.rd;
            end else if (fall) begin
                tx_q <= {tx_q[FRAME_BITS-2:0], 1'b0};
            end
            if (rise && !sd_oe) begin
                rx_q <= {rx_q[NIB_W-2:0], sd_in};
            end
            if (last_fall && rd_q) begin
                rdata <= rx_q;
            end
        end
    end

    // Line is released only inside a read frame.
    assert_release_read_R5: assert property (@(posedge clk) disable iff (rst)
        (run && !sd_oe) |-> rd_q);

endmodule

// File: rtl/rtcn_master.sv
module rtcn_master
    import rtcn_pkg::*;
#(
    parameter int HALF_CYC = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       rd_nwr,
    input  logic [3:0] addr,
    input  logic [3:0] wdata,
    output logic [3:0] rdata,
    output logic       done,
    output logic       busy,
    output logic       ce,
    output logic       sclk,
    output logic       sd_out,
    output logic       sd_oe,
    input  logic       sd_in
);
    logic             run;
    logic             load;
    logic             rise;
    logic             fall;
    logic             last_fall;
    logic [IDX_W-1:0] bit_idx;
    req_t             req;

    assign req  = '{rd: rd_nwr, addr: addr, wdat: wdata};
    assign busy = run;
    assign ce   = run;

    rtcn_clkgen #(.HALF_CYC(HALF_CYC)) u_clk (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .sclk (sclk),
        .rise (rise),
        .fall (fall)
    );

    rtcn_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .fall      (fall),
        .run       (run),
        .load      (load),
        .last_fall (last_fall),
        .bit_idx   (bit_idx),
        .done      (done)
    );

    rtcn_shift u_shf (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .req       (req),
        .rise      (rise),
        .fall      (fall),
        .last_fall (last_fall),
        .run       (run),
        .bit_idx   (bit_idx),
        .sd_in     (sd_in),
        .sd_out    (sd_out),
        .sd_oe     (sd_oe),
        .rdata     (rdata)
    );

    assert_data_steady_R7: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(sd_out));

    assert_oe_in_frame_R10: assert property (@(posedge clk) disable iff (rst)
        sd_oe |-> ce);

endmodule

// File: tb/tb_rtcn_master.sv
module tb_rtcn_master;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;
    localparam int FRAME_CYC  = 32 * HALF;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       rd_nwr = 1'b0;
    logic [3:0] addr = '0;
    logic [3:0] wdata = '0;
    logic [3:0] rdata;
    logic       done, busy, ce, sclk, sd_out, sd_oe;
    logic       sd_in = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    // Behavioural reference state
    int          m_act = 0;
    int          m_t = 0;
    int          m_done = 0;
    int          m_rd = 0;
    logic [15:0] m_frame = '0;
    logic [3:0]  m_rdata = '0;

    // Slave pattern: bit c of a frame is slv_word[15-c]
    logic [15:0] slv_word = '0;
    int          slv_cnt = 0;
    logic        prev_sclk = 1'b0;

    rtcn_master #(.HALF_CYC(HALF)) dut (
        .clk(clk), .rst(rst), .start(start), .rd_nwr(rd_nwr),
        .addr(addr), .wdata(wdata), .rdata(rdata), .done(done),
        .busy(busy), .ce(ce), .sclk(sclk), .sd_out(sd_out),
        .sd_oe(sd_oe), .sd_in(sd_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    // Reference model advance
    always @(posedge clk) begin
        cyc++;
        m_done = 0;
        if (rst) begin
            m_act = 0; m_t = 0; m_rdata = '0;
        end else if (m_act != 0) begin
            if (m_t == FRAME_CYC - 1) begin
                m_act = 0;
                m_done = 1;
                if (m_rd != 0) m_rdata = slv_word[3:0];
            end else begin
                m_t++;
            end
        end else if (start) begin
            m_act = 1; m_t = 0; m_rd = int'(rd_nwr);
            if (rd_nwr) m_frame = {4'b1110, addr, 8'h00};
            else        m_frame = {4'b1010, addr, 4'b1001, wdata};
        end
    end

    // Per-cycle comparison and slave
    always @(negedge clk) begin
        if (!rst) begin
            int bit_n;
            int exp_sclk;
            int exp_oe;
            bit_n    = m_t / (2 * HALF);
            exp_sclk = (m_act != 0 && (m_t % (2 * HALF)) >= HALF) ? 1 : 0;
            exp_oe   = (m_act != 0 && (m_rd == 0 || bit_n < 8)) ? 1 : 0;
            check("R7 sclk", int'(sclk), exp_sclk);
            check("R10 busy", int'(busy), m_act);
            check("R10 ce", int'(ce), m_act);
            check("R8 done", int'(done), m_done);
            check("R4/R5 sd_oe", int'(sd_oe), exp_oe);
            if (exp_oe != 0)
                check("R2/R3/R4 sd_out", int'(sd_out), int'(m_frame[15 - bit_n]));
            check("R6 rdata", int'(rdata), int'(m_rdata));
        end
        if (done) slv_cnt = 0;
        else if (sclk && !prev_sclk) slv_cnt++;
        prev_sclk = sclk;
        sd_in = (slv_cnt < 16) ? slv_word[15 - slv_cnt] : 1'b0;
    end

    task automatic issue(input logic rd, input logic [3:0] a, input logic [3:0] d);
        @(negedge clk);
        start = 1'b1; rd_nwr = rd; addr = a; wdata = d;
        @(negedge clk);
        start = 1'b0; rd_nwr = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 sclk", int'(sclk), 0);
        check("R1 sd_oe", int'(sd_oe), 0);
        check("R1 ce", int'(ce), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 rdata", int'(rdata), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // Writes, several patterns (R2, R3, R4)
        issue(1'b0, 4'h0, 4'hF); wait_done();
        issue(1'b0, 4'hA, 4'h5); wait_done();
        issue(1'b0, 4'hD, 4'h3); wait_done();

        // Reads: discarded nibble opposite to data (R5, R6)
        slv_word = {8'hFF, 4'h6, 4'h9};
        issue(1'b1, 4'h7, 4'h0); wait_done();
        check("R6 read value", int'(rdata), 9);
        slv_word = {8'h00, 4'hF, 4'h0};
        issue(1'b1, 4'hC, 4'hF); wait_done();
        check("R5 discard no effect", int'(rdata), 0);
        slv_word = {8'h5A, 4'h0, 4'hB};
        issue(1'b1, 4'h1, 4'h0); wait_done();
        check("R6 read value", int'(rdata), 11);

        // Write keeps rdata (R6)
        issue(1'b0, 4'h2, 4'h6); wait_done();
        check("R6 rdata held", int'(rdata), 11);

        // R9: start while busy is ignored
        issue(1'b0, 4'h4, 4'h8);
        repeat (10) @(negedge clk);
        start = 1'b1; rd_nwr = 1'b1; addr = 4'hF;
        @(negedge clk);
        start = 1'b0; rd_nwr = 1'b0; addr = '0;
        wait_done();

        // R10: start presented in the done cycle is accepted
        slv_word = {8'h00, 4'h3, 4'hE};
        issue(1'b1, 4'h9, 4'h0);
        while (!done) @(negedge clk);
        start = 1'b1; rd_nwr = 1'b0; addr = 4'h3; wdata = 4'hC;
        @(negedge clk);
        start = 1'b0;
        check("R10 back-to-back busy", int'(busy), 1);
        wait_done();
        check("R6 read before back-to-back", int'(rdata), 14);

        repeat (5) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule